// File: doc/BRIEF.md
# Volume-scaled sample multiply-accumulator

This block weights one 8-bit audio sample by a 6-bit channel volume and folds the product into a running 16-bit signed sum. A mixer controller feeds it one channel at a time and builds each left or right output word from four such products. The finished sum is held on a parallel output for a serial DAC stage.

Each multiply starts with a single-cycle load strobe. The strobe captures the volume, the sample byte, the sample-encoding select and a clear flag. The multiply is a sequential shift-and-add, one volume bit per cycle, followed by one cycle in which the product is added to the sum. When the clear flag was captured, the product replaces the sum instead. The ready output is low while this work is in progress. A load that arrives while ready is low is dropped.

Sample bytes are offset binary by default. When the encoding select is high they are read as two's complement.

Top module: `vol_mac`

## Requirements
- R1: The volume is unsigned. A volume of 0 gives a product of 0, and a volume of 63 gives 63 times the sample value.
- R2: With `twos_i` low, the sample byte is offset binary with its top bit inverted: 0x80 is 0, 0x81 is +1, 0xFF is +127, 0x7F is -1 and 0x00 is -128. The signed value is the byte minus 128.
- R3: With `twos_i` high, bit 7 of the byte is flipped before decoding, so the byte is read as a two's-complement value: 0x7F is +127, 0x80 is -128 and 0xFF is -1.
- R4: A `load_i` pulse sampled while `ready_o` is high captures the volume, the sample, `twos_i` and `clr_i`. `ready_o` is low from the next cycle on.
- R5: `ready_o` is low for exactly VOL_W+1 cycles (7 with defaults) after an accepted load. The sum takes its new value on the same edge at which `ready_o` returns high.
- R6: When the captured `clr_i` is high, the new sum equals the product. When it is low, the new sum is the old sum plus the product.
- R7: A `load_i` pulse sampled while `ready_o` is low is ignored. It changes neither the result nor the timing of the multiply in progress.
- R8: `sum_o` holds its value in every cycle except the one in which a multiply completes.
- R9: After reset, `ready_o` is high and `sum_o` is 0.
- R10: Four full-scale products of the same sign accumulate without wrap: 4 x (-128 x 63) = -32256 and 4 x (127 x 63) = 32004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| vol_i | input | VOL_W (6) | Unsigned channel volume |
| smp_i | input | SMP_W (8) | Sample byte |
| twos_i | input | 1 | 1: sample is two's complement; 0: offset binary |
| load_i | input | 1 | One-cycle strobe that starts a multiply |
| clr_i | input | 1 | Sampled with load; 1 makes the product replace the sum |
| ready_o | output | 1 | High when a new load will be accepted |
| sum_o | output | ACC_W (16) | Signed accumulated sum |

## Verification
The bench builds the block with its default widths: a 6-bit volume, an 8-bit sample and a 16-bit sum. With these widths every sample code and every volume can be reached, and so can the extreme frames of four full-scale products, which come within about 500 of the signed 16-bit limits. The 7-cycle busy window is short, so the bench can measure it for every load and can place a stray load inside it.

// File: rtl/vmac_pkg.sv
package vmac_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_MUL  = 2'd1,
    PH_ACC  = 2'd2
  } phase_e;
endpackage

// File: rtl/vmac_ctrl.sv
module vmac_ctrl #(
  parameter int VOL_W = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic ready_o,
  output logic accept_o,
  output logic step_en_o,
  output logic acc_fire_o
);
  import vmac_pkg::*;

  localparam int CNT_W = (VOL_W > 1) ? $clog2(VOL_W) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(VOL_W - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] step_q;

  assign ready_o    = (phase_q == PH_IDLE);
  assign accept_o   = ready_o && load_i;
  assign step_en_o  = (phase_q == PH_MUL);
  assign acc_fire_o = (phase_q == PH_ACC);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      step_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (load_i) begin
            phase_q <= PH_MUL;
            step_q  <= '0;
          end
        end
        PH_MUL: begin
          if (step_q == LAST_STEP) phase_q <= PH_ACC;
          else                     step_q  <= step_q + 1'b1;
        end
        PH_ACC:  phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vmac_mult.sv
module vmac_mult #(
  parameter int SMP_W  = 8,
  parameter int VOL_W  = 6,
  parameter int PROD_W = SMP_W + VOL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              step_en_i,
  input  logic [VOL_W-1:0]  vol_i,
  input  logic [SMP_W-1:0]  smp_i,
  output logic [PROD_W-1:0] prod_o
);
  logic [PROD_W-1:0] mcand_q;
  logic [VOL_W-1:0]  mplier_q;
  logic [PROD_W-1:0] prod_q;

  function automatic logic [PROD_W-1:0] sext_smp(input logic [SMP_W-1:0] s);
    return {{(PROD_W-SMP_W){s[SMP_W-1]}}, s};
  endfunction

  function automatic logic [PROD_W-1:0] partial(input logic [PROD_W-1:0] m, input logic b);
    return b ? m : '0;
  endfunction

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      prod_q   <= '0;
    end else if (capture_i) begin
      mcand_q  <= sext_smp(smp_i);
      mplier_q <= vol_i;
      prod_q   <= '0;
    end else if (step_en_i) begin
      prod_q   <= prod_q + partial(mcand_q, mplier_q[0]);
      mcand_q  <= mcand_q << 1;
      mplier_q <= mplier_q >> 1;
    end
  end

  assign prod_o = prod_q;
endmodule

// File: rtl/vmac_accum.sv
module vmac_accum #(
  parameter int PROD_W = 14,
  parameter int ACC_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              clr_i,
  input  logic              fire_i,
  input  logic [PROD_W-1:0] prod_i,
  output logic [ACC_W-1:0]  sum_o
);
  logic             clr_q;
  logic [ACC_W-1:0] sum_q;

  function automatic logic [ACC_W-1:0] widen(input logic [PROD_W-1:0] p);
    return {{(ACC_W-PROD_W){p[PROD_W-1]}}, p};
  endfunction

  function automatic logic [ACC_W-1:0] next_sum(input logic [ACC_W-1:0] cur,
                                                input logic [PROD_W-1:0] p,
                                                input logic restart);
    return restart ? widen(p) : cur + widen(p);
  endfunction

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      clr_q <= 1'b0;
      sum_q <= '0;
    end else begin
      if (capture_i) clr_q <= clr_i;
      if (fire_i)    sum_q <= next_sum(sum_q, prod_i, clr_q);
    end
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/vol_mac.sv
module vol_mac #(
  parameter int VOL_W = 6,
  parameter int SMP_W = 8,
  parameter int ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VOL_W-1:0] vol_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             twos_i,
  input  logic             load_i,
  input  logic             clr_i,
  output logic             ready_o,
  output logic [ACC_W-1:0] sum_o
);
  localparam int PROD_W = SMP_W + VOL_W;

  logic              accept;
  logic              step_en;
  logic              acc_fire;
  logic [SMP_W-1:0]  smp_signed;
  logic [PROD_W-1:0] prod;

  // Offset binary has its top bit inverted; two's-complement mode flips it
  // once more, which amounts to taking the byte unchanged.
  function automatic logic [SMP_W-1:0] decode_sample(input logic [SMP_W-1:0] b,
                                                     input logic twos);
    return {b[SMP_W-1] ^ ~twos, b[SMP_W-2:0]};
  endfunction

  assign smp_signed = decode_sample(smp_i, twos_i);

  vmac_ctrl #(.VOL_W(VOL_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .ready_o    (ready_o),
    .accept_o   (accept),
    .step_en_o  (step_en),
    .acc_fire_o (acc_fire)
  );

  vmac_mult #(.SMP_W(SMP_W), .VOL_W(VOL_W), .PROD_W(PROD_W)) u_mult (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (accept),
    .step_en_i (step_en),
    .vol_i     (vol_i),
    .smp_i     (smp_signed),
    .prod_o    (prod)
  );

  vmac_accum #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_accum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (accept),
    .clr_i     (clr_i),
    .fire_i    (acc_fire),
    .prod_i    (prod),
    .sum_o     (sum_o)
  );
endmodule

// File: rtl/vmac_chk.sv
module vmac_chk #(
  parameter int VOL_W  = 6,
  parameter int SMP_W  = 8,
  parameter int ACC_W  = 16,
  parameter int PROD_W = SMP_W + VOL_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic              ready_o,
  input logic [ACC_W-1:0]  sum_o,
  input logic              accept,
  input logic              acc_fire,
  input logic [PROD_W-1:0] prod
);
  localparam int VMAX = (1 << VOL_W) - 1;
  localparam int PMIN = -(1 << (SMP_W - 1)) * VMAX;
  localparam int PMAX = ((1 << (SMP_W - 1)) - 1) * VMAX;
  localparam int LAT  = VOL_W + 2;

  logic [7:0] busy_cnt;

  function automatic int as_int(input logic [PROD_W-1:0] p);
    return int'($signed(p));
  endfunction

  always_ff @(posedge clk_i) begin
    if (!rst_ni)       busy_cnt <= '0;
    else if (accept)   busy_cnt <= 8'd1;
    else if (!ready_o) busy_cnt <= busy_cnt + 8'd1;
  end

  AST_READY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && ready_o) |=> !ready_o); // R4

  AST_BUSY_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (busy_cnt == 8'(LAT))); // R5

  AST_SUM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> $stable(sum_o)); // R8

  AST_PROD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_fire |-> (as_int(prod) >= PMIN && as_int(prod) <= PMAX)); // R10
endmodule

bind vol_mac vmac_chk #(.VOL_W(VOL_W), .SMP_W(SMP_W), .ACC_W(ACC_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .load_i   (load_i),
  .ready_o  (ready_o),
  .sum_o    (sum_o),
  .accept   (accept),
  .acc_fire (acc_fire),
  .prod     (prod)
);

// File: tb/vol_mac_tb_top.sv
module vol_mac_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  vol_i = '0;
  logic [7:0]  smp_i = '0;
  logic        twos_i = 1'b0;
  logic        load_i = 1'b0;
  logic        clr_i = 1'b0;
  logic        ready_o;
  logic [15:0] sum_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  vol_mac dut_i (
    .clk_i (clk), .rst_ni (rst_ni), .vol_i (vol_i), .smp_i (smp_i),
    .twos_i (twos_i), .load_i (load_i), .clr_i (clr_i),
    .ready_o (ready_o), .sum_o (sum_o)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  int    exp_q[$];
  string tag_q[$];
  int    model_sum = 0;
  int    last_sum = 0;
  int    low_cnt = 0;
  logic  prev_ready = 1'b1;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Independent decode: offset binary is byte-128, two's complement is the signed byte.
  function automatic int sample_value(logic [7:0] b, bit twos);
    if (twos) return (int'(b) >= 128) ? int'(b) - 256 : int'(b);
    return int'(b) - 128;
  endfunction

  task automatic do_load(int vol, int smp, bit twos, bit clr, string tag);
    int p;
    while (!ready_o) @(negedge clk);
    p = sample_value(8'(smp), twos) * vol;
    model_sum = clr ? p : model_sum + p;
    exp_q.push_back(model_sum);
    tag_q.push_back(tag);
    vol_i = 6'(vol); smp_i = 8'(smp); twos_i = twos; clr_i = clr; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    check("R4 ready low after load", int'(ready_o), 0);
  endtask

  task automatic stray_load();
    vol_i = 6'd63; smp_i = 8'hFF; twos_i = 1'b0; clr_i = 1'b1; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  // Monitor: pops one expected sum per completion, checks busy length and hold.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni) begin
        if (!ready_o) begin
          low_cnt++;
          check("R8 sum held while busy", int'($signed(sum_o)), last_sum);
        end else if (!prev_ready) begin
          check("R5 busy cycles", low_cnt, 7);
          if (exp_q.size() == 0) check("R6 unexpected completion", 1, 0);
          else check(tag_q.pop_front(), int'($signed(sum_o)), exp_q.pop_front());
          last_sum = int'($signed(sum_o));
          low_cnt = 0;
        end else begin
          check("R8 sum held while idle", int'($signed(sum_o)), last_sum);
        end
        prev_ready = ready_o;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL R5 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R9 reset sum", int'($signed(sum_o)), 0);
    check("R9 reset ready", int'(ready_o), 1);

    // R2 offset-binary codes at volume 1
    do_load(1, 'h80, 0, 1, "R2 0x80 is zero");
    do_load(1, 'hFF, 0, 1, "R2 0xFF is +127");
    do_load(1, 'h81, 0, 1, "R2 0x81 is +1");
    do_load(1, 'h7F, 0, 1, "R2 0x7F is -1");
    do_load(1, 'h00, 0, 1, "R2 0x00 is -128");
    // R1 volume extremes
    do_load(0, 'hFF, 0, 1, "R1 volume 0 silences");
    do_load(63, 'hFF, 0, 1, "R1 volume 63 full scale");
    // R3 two's-complement mode
    do_load(63, 'h7F, 1, 1, "R3 0x7F is +127");
    do_load(5, 'h80, 1, 1, "R3 0x80 is -128");
    do_load(9, 'hFF, 1, 1, "R3 0xFF is -1");
    // R6 a frame of four: clear then three adds
    do_load(10, 'h90, 0, 1, "R6 frame first replaces");
    do_load(20, 'h70, 0, 0, "R6 frame add 2");
    do_load(33, 'hC4, 1, 0, "R6 frame add 3");
    do_load(47, 'h05, 0, 0, "R6 frame add 4");
    // R7 stray load during busy is ignored
    do_load(17, 'hA0, 0, 1, "R7 result unaffected by stray load");
    stray_load();
    do_load(3, 'h60, 0, 0, "R7 add after stray load");
    stray_load();
    // R10 full-scale frames
    do_load(63, 'h00, 0, 1, "R10 negative frame 1");
    do_load(63, 'h00, 0, 0, "R10 negative frame 2");
    do_load(63, 'h80, 1, 0, "R10 negative frame 3");
    do_load(63, 'h00, 0, 0, "R10 negative frame 4");
    do_load(63, 'hFF, 0, 1, "R10 positive frame 1");
    do_load(63, 'h7F, 1, 0, "R10 positive frame 2");
    do_load(63, 'hFF, 0, 0, "R10 positive frame 3");
    do_load(63, 'hFF, 0, 0, "R10 positive frame 4");
    // R6 pattern sweep, clear on every fourth load
    for (int k = 0; k < 24; k++) begin
      do_load((k * 13 + 5) % 64, (k * 37 + 11) % 256, k[0], (k % 4) == 0, "R6 sweep");
    end

    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule